// File: doc/BRIEF.md
# Four-Level Band Current Comparator

This block picks the voltage level for one winding of a multilevel reluctance-motor drive. Each cycle it may receive a signed current error (reference minus measured) with a valid strobe, together with an unsigned band width `band`. It compares the error against four thresholds built from that width: +2·band, +band, 0 and −band. From the result it produces a level code from 1 to 4. Code 4 applies the full positive voltage, which is both capacitors in series. Code 3 applies the intermediate positive voltage. Code 2 applies zero volts. Code 1 applies the full negative voltage, which demagnetises the winding.

The thresholds divide the error axis into five regions. In the outer two regions the code is fixed. In the three middle regions two adjacent codes are allowed. There the block keeps its previous code if that code is allowed, and otherwise moves to the allowed code nearest to it. This keeps the output from chattering when the error sits near a threshold.

A four-phase machine uses four instances, one per phase. Each instance has a conduction-window enable. While the enable is low, the instance forces code 1.

Top module: `band_level_cmp`

## Requirements
- R1: A valid sample with error ≥ +2·band and enable high gives code 4 on the next clock.
- R2: A valid sample with error < −band and enable high gives code 1 on the next clock.
- R3: A valid sample with +band ≤ error < +2·band and enable high keeps a previous code of 3 or 4. Any other previous code becomes 3.
- R4: A valid sample with 0 ≤ error < +band and enable high keeps a previous code of 2 or 3. A previous code of 4 becomes 3, and a previous code of 1 becomes 2.
- R5: A valid sample with −band ≤ error < 0 and enable high keeps a previous code of 1 or 2. Any other previous code becomes 2.
- R6: After reset the code is 2 and `lvl_upd` is 0.
- R7: With enable high and no valid sample, the code holds. `lvl_upd` is high exactly in the cycle after each valid sample.
- R8: Enable low forces code 1 on the next clock, whether or not a sample is valid.
- R9: The thresholds are computed wide enough that 2·band and −band never wrap. With the largest band, a maximum positive error stays in the [0, band) region and the most negative error stays in the [−band, 0) region.
- R10: The code is always 1, 2, 3 or 4. It is a plain 3-bit binary value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_vld | input | 1 | Error sample valid |
| err | input | EW | Signed current error, two's complement |
| band | input | BW | Unsigned band width |
| cond_en | input | 1 | Conduction-window enable; low forces code 1 |
| lvl | output | 3 | Level code, 1 to 4 |
| lvl_upd | output | 1 | Pulses in the cycle the code reflects a new sample |

## Verification
The only state in the block is the previous code, so a wrong stored code appears at the ports on the very next valid sample that falls in a two-choice region. In that region the output would then differ from the kept code or from the nearest allowed code. The bench therefore walks each middle region starting from each of the four previous codes. It also checks codes across the outer regions, the forced demagnetisation and the extreme band. A wrong threshold shows up as a code change one sample early or late at the region edges, so the bench drives errors exactly at and one count below each threshold.

// File: rtl/band_level_cmp.sv
module band_level_cmp #(
  parameter int EW = 12,
  parameter int BW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_vld,
  input  logic signed [EW-1:0] err,
  input  logic        [BW-1:0] band,
  input  logic                 cond_en,
  output logic        [2:0]    lvl,
  output logic                 lvl_upd
);
  localparam int W = ((EW > BW) ? EW : BW) + 2;

  logic signed [W-1:0] e_x, d1, d2, dn;
  logic [2:0] nxt;

  assign e_x = W'(err);
  assign d1  = signed'({{(W-BW){1'b0}}, band});
  assign d2  = d1 <<< 1;
  assign dn  = -d1;

  wire r_top = (e_x >= d2);
  wire r_hi  = (e_x >= d1) && !r_top;
  wire r_mid = (e_x >= 0)  && (e_x < d1);
  wire r_lo  = (e_x >= dn) && (e_x < 0);

  always_comb begin
    if (r_top)      nxt = 3'd4;
    else if (r_hi)  nxt = (lvl >= 3'd3) ? lvl : 3'd3;
    else if (r_mid) nxt = (lvl == 3'd4) ? 3'd3 : (lvl == 3'd1) ? 3'd2 : lvl;
    else if (r_lo)  nxt = (lvl <= 3'd2) ? lvl : 3'd2;
    else            nxt = 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= 3'd2;
      lvl_upd <= 1'b0;
    end else begin
      lvl_upd <= err_vld;
      if (!cond_en)     lvl <= 3'd1;
      else if (err_vld) lvl <= nxt;
    end
  end

  assert_full_pos_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && cond_en && r_top) |=> (lvl == 3'd4));
  assert_full_neg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && cond_en && !r_top && !r_hi && !r_mid && !r_lo) |=> (lvl == 3'd1));
  assert_hi_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && cond_en && r_hi && lvl >= 3'd3) |=> $stable(lvl));
  assert_mid_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && cond_en && r_mid) |=> (lvl == 3'd2 || lvl == 3'd3));
  assert_lo_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && cond_en && r_lo) |=> (lvl == 3'd1 || lvl == 3'd2));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_en && !err_vld) |=> $stable(lvl));
  assert_upd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |=> lvl_upd);
  assert_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_en |=> (lvl == 3'd1));
  assert_thr_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn <= 0) && (d1 <= d2));

  always_comb
    if (rst_n) assert_code_range_R10: assert (lvl >= 3'd1 && lvl <= 3'd4);
endmodule

// File: tb/sim_band_level_cmp.sv
module sim_band_level_cmp;
  localparam int EW = 12;
  localparam int BW = 12;

  logic clk = 0, rst_n = 0, err_vld = 0, cond_en = 1;
  logic signed [EW-1:0] err = '0;
  logic [BW-1:0] band = '0;
  logic [2:0] lvl;
  logic lvl_upd;

  int checks = 0, fails = 0, prev = 2;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  band_level_cmp #(.EW(EW), .BW(BW)) u0 (.clk(clk), .rst_n(rst_n), .err_vld(err_vld),
    .err(err), .band(band), .cond_en(cond_en), .lvl(lvl), .lvl_upd(lvl_upd));

  function automatic int model(int p, int e, int b, bit en);
    if (!en) return 1;
    if (e >= 2*b) return 4;
    if (e >= b) return (p >= 3) ? p : 3;
    if (e >= 0) return (p == 4) ? 3 : (p == 1) ? 2 : p;
    if (e >= -b) return (p <= 2) ? p : 2;
    return 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int e, int b, bit en, string tag);
    @(negedge clk);
    err = EW'(e); band = BW'(b); cond_en = en; err_vld = 1;
    prev = model(prev, e, b, en);
    exp_q.push_back(prev); tag_q.push_back(tag);
    @(negedge clk);
    err_vld = 0; cond_en = 1;
  endtask

  task automatic set_prev(int code, int b);
    case (code)
      1: drive(-b - 1, b, 1, "R2");
      2: begin drive(-b - 1, b, 1, "R2"); drive(0, b, 1, "R4"); end
      3: begin drive(2*b, b, 1, "R1"); drive(0, b, 1, "R4"); end
      default: drive(2*b, b, 1, "R1");
    endcase
  endtask

  always @(negedge clk) begin
    if (lvl_upd) begin
      if (exp_q.size() == 0) chk("R7", 1, 0);
      else chk(tag_q.pop_front(), int'(lvl), exp_q.pop_front());
    end
    if (rst_n) chk("R10", int'(lvl >= 1 && lvl <= 4), 1);
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6", int'(lvl), 2);
    chk("R6", int'(lvl_upd), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R6", int'(lvl), 2);

    drive(200, 100, 1, "R1");
    drive(199, 100, 1, "R3");
    drive(100, 100, 1, "R3");
    drive(99, 100, 1, "R4");
    drive(0, 100, 1, "R4");
    drive(-1, 100, 1, "R5");
    drive(-100, 100, 1, "R5");
    drive(-101, 100, 1, "R2");
    drive(-100, 100, 1, "R5");
    drive(0, 100, 1, "R4");
    drive(150, 100, 1, "R3");

    for (int p = 1; p <= 4; p++) begin
      set_prev(p, 50); drive(75, 50, 1, "R3");
      set_prev(p, 50); drive(20, 50, 1, "R4");
      set_prev(p, 50); drive(-20, 50, 1, "R5");
    end

    set_prev(3, 50);
    repeat (2) @(negedge clk);
    err = 12'sd500;
    repeat (3) @(negedge clk);
    chk("R7", int'(lvl), 3);
    chk("R7", int'(lvl_upd), 0);

    cond_en = 0;
    @(negedge clk);
    chk("R8", int'(lvl), 1);
    chk("R8", int'(lvl_upd), 0);
    cond_en = 1; prev = 1;
    drive(500, 50, 0, "R8");

    drive(2047, 4095, 1, "R9");
    set_prev(4, 10);
    drive(2047, 4095, 1, "R9");
    drive(-2048, 4095, 1, "R9");
    drive(-2048, 0, 1, "R2");
    drive(0, 0, 1, "R1");

    for (int i = 0; i < 400; i++)
      drive($urandom_range(0, 4095) - 2048, $urandom_range(0, 1200), ($urandom_range(0, 9) != 0), "R3");

    repeat (3) @(negedge clk);
    chk("R7", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule